// File: doc/BRIEF.md
# Forced-High Unit Delay

This block is a single-bit delay stage with an override. A data bit is passed to the output one clock later. A separate force input drives the output high at once, in the same cycle, through a combinational path. The same force also loads a 1 into the stored bit, so the output stays high for the following cycle as well.

The design is built only from four primitive cells:
- a constant-high source,
- an inverter,
- a 2:1 multiplexer,
- a one-cycle delay flop that comes up holding 0 at power-on.

The inverters and multiplexers have no delay. The stored bit is kept in inverted form, so the power-on value of the flop makes the output read high in the first cycle. This happens even when force is not asserted.

A typical use is a flag or enable line that must be held asserted while an initialising condition is present and for one cycle after it ends. Once the condition ends, the line follows its normal source with one cycle of latency.

Top module: `rfd_delay_top`

## Requirements
- R1: While `force_hi` is 1, `dout` is 1 in that same cycle, before any clock edge.
- R2: If `force_hi` was 1 at the previous rising edge of `clk`, `dout` is 1 for the whole following cycle, whatever `din` was.
- R3: If `force_hi` is 0 now and was 0 at the previous rising edge, `dout` equals the value `din` had at that previous edge.
- R4: `din` reaches `dout` only through the flop: changing `din` between two edges leaves `dout` unchanged until the next rising edge.
- R5: From power-on, before any clock edge and with `force_hi` at 0, `dout` reads 1.
- R6: After the first rising edge, `dout` is never X or Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stored bit updates on the rising edge |
| force_hi | input | 1 | Override: drives `dout` high now and for the next cycle |
| din | input | 1 | Data bit, sampled at each rising edge |
| dout | output | 1 | Delayed data, or 1 under override |

## Verification
The block has no parameters, so the bench builds it in its only configuration. Every sequence of force and data values is therefore within reach. The stimulus covers these cases:
- single-cycle and back-to-back force pulses,
- force released while `din` is 0, which shows the second held-high cycle,
- `din` toggled inside a cycle with no force, to show there is no data-to-output path,
- the first cycle after power-on with force low, which shows the inverted-storage start value.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
    localparam logic LVL_HI = 1'b1;
    localparam logic LVL_LO = 1'b0;
endpackage

// File: rtl/rfd_prims.sv
// Constant-high source
module rfd_one
    import rfd_pkg::*;
(
    output logic y
);
    assign y = LVL_HI;
endmodule

// Zero-delay inverter
module rfd_inv (
    input  logic a,
    output logic y
);
    assign y = ~a;
endmodule

// Zero-delay 2:1 multiplexer; sel=1 picks a1
module rfd_mux2 (
    input  logic sel,
    input  logic a1,
    input  logic a0,
    output logic y
);
    assign y = sel ? a1 : a0;
endmodule

// Unit-delay flop, holds 0 from power-on
module rfd_dreg
    import rfd_pkg::*;
(
    input  logic clk,
    input  logic d,
    output logic q
);
    logic q_r = LVL_LO;
    always_ff @(posedge clk) begin
        q_r <= d;
    end
    assign q = q_r;
endmodule

// File: rtl/rfd_delay_top.sv
module rfd_delay_top (
    input  logic clk,
    input  logic force_hi,
    input  logic din,
    output logic dout
);
    logic hi;          // constant 1
    logic nxt_true;    // bit to be stored, true polarity
    logic nxt_inv;     // bit to be stored, inverted
    logic st_inv;      // flop output, inverted storage
    logic st_true;     // stored bit, true polarity

    rfd_one  u_one    (.y(hi));

    // Input side: force loads a 1, otherwise data
    rfd_mux2 u_mux_in (.sel(force_hi), .a1(hi), .a0(din), .y(nxt_true));

    // Inverted storage: flop's power-on 0 reads back as 1
    rfd_inv  u_inv_in (.a(nxt_true), .y(nxt_inv));
    rfd_dreg u_store  (.clk(clk), .d(nxt_inv), .q(st_inv));
    rfd_inv  u_inv_out(.a(st_inv), .y(st_true));

    // Output side: current force wins combinationally
    rfd_mux2 u_mux_out(.sel(force_hi), .a1(hi), .a0(st_true), .y(dout));
endmodule

// File: rtl/rfd_delay_chk.sv
module rfd_delay_chk (
    input logic clk,
    input logic force_hi,
    input logic din,
    input logic dout
);
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    AST_FORCE_NOW: assert property (@(posedge clk) disable iff (!armed)
        force_hi |-> dout); // R1

    AST_FORCE_TAIL: assert property (@(posedge clk) disable iff (!armed)
        force_hi |=> dout); // R2

    AST_DELAY_DATA: assert property (@(posedge clk) disable iff (!armed)
        (!force_hi && !$past(force_hi)) |-> (dout == $past(din))); // R3

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!armed)
        !$isunknown(dout)); // R6
endmodule

bind rfd_delay_top rfd_delay_chk u_chk (
    .clk(clk), .force_hi(force_hi), .din(din), .dout(dout)
);

// File: tb/rfd_delay_top_bench.sv
`timescale 1ns/1ps
module rfd_delay_top_bench;
    logic clk = 1'b0;
    logic force_hi = 1'b0;
    logic din = 1'b0;
    logic dout;

    int checks = 0;
    int fails = 0;
    logic prev_f = 1'b0;
    logic prev_d = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    rfd_delay_top u_rfd_delay_top (
        .clk(clk), .force_hi(force_hi), .din(din), .dout(dout)
    );

    function automatic logic expect_out(logic f, logic pf, logic pd);
        return (f || pf) ? 1'b1 : pd;
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (dout !== exp) begin
            fails++;
            $display("FAIL %s: dout=%b expected=%b at %0t", req, dout, exp, $time);
        end
    endtask

    // Drive after a falling edge, check mid-low-phase, then update the model at the rising edge
    task automatic step(input logic f, input logic d, input string req);
        @(negedge clk);
        force_hi = f;
        din = d;
        #0.5;
        check(req, expect_out(f, prev_f, prev_d));
        @(posedge clk);
        prev_f = f;
        prev_d = d;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R5: power-on value with force low, before the first edge
        #1;
        check("R5", 1'b1);
        // R1 before any edge: force raises the output at once
        force_hi = 1'b1;
        #0.5;
        check("R1", 1'b1);
        force_hi = 1'b0;
        @(posedge clk);
        prev_f = 1'b0;
        prev_d = 1'b0;

        // R3: plain data flow
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R3");
        // R1/R2: single force pulse while data is 0
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, "R3");
        // back-to-back force
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R3");

        // R4: toggle din within a cycle, output must not move
        @(negedge clk);
        force_hi = 1'b0;
        din = 1'b1;
        #0.5;
        check("R4", expect_out(1'b0, prev_f, prev_d));
        din = 1'b0;
        #0.5;
        check("R4", expect_out(1'b0, prev_f, prev_d));
        din = 1'b1;
        #0.5;
        check("R4", expect_out(1'b0, prev_f, prev_d));
        @(posedge clk);
        prev_f = 1'b0;
        prev_d = 1'b1;
        step(1'b0, 1'b0, "R3");

        // Random mix, about a quarter of cycles forced
        for (int i = 0; i < 400; i++) begin
            logic rf;
            logic rd;
            rf = ($urandom % 4) == 0;
            rd = $urandom % 2;
            step(rf, rd, rf ? "R1" : (prev_f ? "R2" : "R3"));
            checks++;
            if ($isunknown(dout)) begin
                fails++;
                $display("FAIL R6: dout=%b expected=known", dout);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule